// File: doc/BRIEF.md
# Backplane Transfer Timeout Monitor

This block times each data transfer cycle on an asynchronous parallel backplane bus and forces error termination of any cycle that lasts too long. A cycle starts when the address strobe goes active. The timer runs while the address strobe stays active and nothing has ended the cycle yet. A data acknowledge from a slave ends it normally, and so does a bus error raised by another board. If neither arrives within the limit, the monitor drives the bus error line. The master then terminates the cycle with an error.

The strobes and responses arrive asynchronously, so they pass through a synchronizer of parameterized depth before any logic sees them. The limit is a parameter in clock cycles: 128 µs divided by the clock period, which is 2048 cycles at 16 MHz. A control/status register supplies an enable and a write-one-to-clear strobe. The block reports back a sticky flag that is set only when the bus error was produced by this monitor, so that software can tell such errors apart from those raised by other boards.

Top module: `bus_cycle_watchdog`

## Requirements
- R1: After reset the bus error drive and the timeout flag are both 0.
- R2: With the monitor enabled and no response, the bus error drive (active high) goes to 1 exactly LIMIT clocks after the synchronized address strobe becomes active. That is SYNC+LIMIT rising edges after `as_n` falls at the pins.
- R3: A data acknowledge (`dtack_n` low) that is driven no later than LIMIT-1 clocks after `as_n` falls prevents the bus error and leaves the flag at 0. One driven at LIMIT clocks or later does not prevent it.
- R4: Once asserted, the bus error drive stays at 1 until the address strobe and both data strobes are all inactive. It drops SYNC+1 edges after the last strobe is released.
- R5: With `mon_en` at 0 no bus error is driven. Dropping `mon_en` while the drive is active removes the drive at the next edge.
- R6: The timeout flag goes to 1 in the same edge as the monitor's bus error. It stays at 1 after the cycle ends and after the drive is removed.
- R7: A one-clock pulse on `stat_clr` clears the flag. If the pulse coincides with a new timeout, the flag is set.
- R8: A bus error from another board (`berr_bus_n` low) ends timing under the same timing rule as R3. It never sets the flag and never causes this block to drive.
- R9: Each cycle is timed on its own. Releasing the address strobe reloads the timer, so a run of cycles that are each shorter than the limit never produces a bus error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mon_en | input | 1 | Monitor enable from the control register |
| stat_clr | input | 1 | Write-one-to-clear pulse for the timeout flag |
| as_n | input | 1 | Backplane address strobe, active low, asynchronous |
| ds_n | input | 2 | Backplane data strobes, active low, asynchronous |
| dtack_n | input | 1 | Data acknowledge, active low, asynchronous |
| berr_bus_n | input | 1 | Sensed bus error line, active low, asynchronous |
| berr_drv | output | 1 | Enables the bus error driver, active high |
| tmo_stat | output | 1 | Sticky flag for a bus error raised by this monitor |

## Verification
The hardest situation is a response that lands exactly on the limit, together with a flag clear that coincides with a new timeout. Both depend on where the asynchronous inputs sit inside the synchronizer at the firing edge. The bench runs with a short limit and sweeps the acknowledge and the foreign bus error over every clock offset from zero to past the limit. For each offset it predicts from arithmetic whether the drive fires and where. It also places a clear pulse on the clock just before the predicted firing edge.

// File: rtl/bus_cycle_watchdog.sv
module bus_cycle_watchdog #(
  parameter int LIMIT = 2048,
  parameter int SYNC  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mon_en,
  input  logic       stat_clr,
  input  logic       as_n,
  input  logic [1:0] ds_n,
  input  logic       dtack_n,
  input  logic       berr_bus_n,
  output logic       berr_drv,
  output logic       tmo_stat
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [4:0] sr [SYNC];
  logic [4:0] raw_n;
  logic       as_s, ack_s, xb_s, cyc_s, term, fire;
  logic [1:0] ds_s;
  logic [CW-1:0] cnt;
  logic       done, berr_q, stat_q;

  assign raw_n = {as_n, ds_n, dtack_n, berr_bus_n};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC; i++) sr[i] <= '1;
    end else begin
      sr[0] <= raw_n;
      for (int i = 1; i < SYNC; i++) sr[i] <= sr[i-1];
    end
  end

  assign as_s  = ~sr[SYNC-1][4];
  assign ds_s  = ~sr[SYNC-1][3:2];
  assign ack_s = ~sr[SYNC-1][1];
  assign xb_s  = ~sr[SYNC-1][0];
  assign cyc_s = as_s | (|ds_s);
  assign term  = ack_s | xb_s;
  assign fire  = mon_en & as_s & ~done & ~term & ~berr_q & (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !as_s || !mon_en) cnt <= '0;
    else if (!berr_q && cnt != LAST) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) done <= 1'b0;
    else        done <= cyc_s & (done | term);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !mon_en || !cyc_s) berr_q <= 1'b0;
    else if (fire)                   berr_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        stat_q <= 1'b0;
    else if (fire)     stat_q <= 1'b1;
    else if (stat_clr) stat_q <= 1'b0;
  end

  assign berr_drv = berr_q;
  assign tmo_stat = stat_q;

  AST_FIRE_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(berr_drv) |-> ($past(cnt) == LAST)); // R2
  AST_NO_BERR_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !berr_drv) |=> !berr_drv); // R3
  AST_BERR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (berr_drv && cyc_s && mon_en) |=> berr_drv); // R4
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !mon_en |=> !berr_drv); // R5
  AST_FLAG_WITH_BERR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(berr_drv) |-> tmo_stat); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_stat && !stat_clr) |=> tmo_stat); // R6
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && !fire) |=> !tmo_stat); // R7
endmodule

// File: tb/bus_cycle_watchdog_test.sv
module bus_cycle_watchdog_test;
  localparam int LIMIT = 16;
  localparam int SYNC  = 2;
  localparam int FIRE  = SYNC + LIMIT;

  logic clk = 1'b0, rst_n = 1'b0, mon_en = 1'b0, stat_clr = 1'b0;
  logic as_n = 1'b1, dtack_n = 1'b1, berr_bus_n = 1'b1;
  logic [1:0] ds_n = 2'b11;
  logic berr_drv, tmo_stat;
  int checks = 0, errors = 0, cyc = 0;

  bus_cycle_watchdog #(.LIMIT(LIMIT), .SYNC(SYNC)) uut (
    .clk(clk), .rst_n(rst_n), .mon_en(mon_en), .stat_clr(stat_clr),
    .as_n(as_n), .ds_n(ds_n), .dtack_n(dtack_n), .berr_bus_n(berr_bus_n),
    .berr_drv(berr_drv), .tmo_stat(tmo_stat));

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic release_all();
    as_n = 1'b1; ds_n = 2'b11; dtack_n = 1'b1; berr_bus_n = 1'b1;
  endtask

  task automatic clear_flag();
    @(negedge clk); stat_clr = 1'b1;
    @(negedge clk); stat_clr = 1'b0;
    chk(tmo_stat == 1'b0, "R7 clear", tmo_stat, 0);
  endtask

  // kind: 0 none, 1 data acknowledge, 2 foreign bus error
  task automatic run(input int ack_at, input int kind, input bit en);
    bit exp_fire;
    string tag;
    exp_fire = en && (kind == 0 || ack_at >= LIMIT);
    tag = !en ? "R5 disabled" : (kind == 1 ? "R3 ack" : (kind == 2 ? "R8 foreign" : "R2 timeout"));
    mon_en = en;
    @(negedge clk);
    as_n = 1'b0; ds_n = 2'b00;
    if (kind == 1 && ack_at == 0) dtack_n = 1'b0;
    if (kind == 2 && ack_at == 0) berr_bus_n = 1'b0;
    for (int k = 1; k <= FIRE + 3; k++) begin
      @(negedge clk);
      chk(berr_drv == (exp_fire && k >= FIRE), tag, berr_drv, int'(exp_fire && k >= FIRE));
      if (kind == 1 && k == ack_at) dtack_n = 1'b0;
      if (kind == 2 && k == ack_at) berr_bus_n = 1'b0;
    end
    release_all();
    for (int r = 1; r <= SYNC + 1; r++) begin
      @(negedge clk);
      chk(berr_drv == (exp_fire && r <= SYNC), "R4 release", berr_drv, int'(exp_fire && r <= SYNC));
    end
    repeat (2) @(negedge clk);
    chk(tmo_stat == exp_fire, kind == 2 ? "R8 flag" : "R6 flag", tmo_stat, int'(exp_fire));
    clear_flag();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(berr_drv == 1'b0 && tmo_stat == 1'b0, "R1 reset", {berr_drv, tmo_stat}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(berr_drv == 1'b0 && tmo_stat == 1'b0, "R1 after reset", {berr_drv, tmo_stat}, 0);

    run(0, 0, 1'b1);
    run(0, 0, 1'b0);
    for (int kind = 1; kind <= 2; kind++)
      for (int a = 0; a <= LIMIT + 2; a++) run(a, kind, 1'b1);

    // R4: address strobe released, data strobe still held
    mon_en = 1'b1;
    @(negedge clk); as_n = 1'b0; ds_n = 2'b10;
    repeat (FIRE) @(negedge clk);
    chk(berr_drv == 1'b1, "R4 fired", berr_drv, 1);
    as_n = 1'b1;
    for (int r = 1; r <= SYNC + 4; r++) begin
      @(negedge clk);
      chk(berr_drv == 1'b1, "R4 ds held", berr_drv, 1);
    end
    ds_n = 2'b11;
    for (int r = 1; r <= SYNC + 1; r++) begin
      @(negedge clk);
      chk(berr_drv == (r <= SYNC), "R4 ds release", berr_drv, int'(r <= SYNC));
    end
    clear_flag();

    // R5: enable dropped while driving; R6 flag survives
    @(negedge clk); as_n = 1'b0; ds_n = 2'b00;
    repeat (FIRE) @(negedge clk);
    chk(berr_drv == 1'b1, "R5 before drop", berr_drv, 1);
    mon_en = 1'b0;
    @(negedge clk);
    chk(berr_drv == 1'b0, "R5 drop", berr_drv, 0);
    chk(tmo_stat == 1'b1, "R6 kept", tmo_stat, 1);
    release_all();
    repeat (SYNC + 2) @(negedge clk);
    mon_en = 1'b1;
    clear_flag();

    // R7: clear coinciding with a new timeout
    @(negedge clk); as_n = 1'b0; ds_n = 2'b00;
    repeat (FIRE - 1) @(negedge clk);
    stat_clr = 1'b1;
    @(negedge clk); stat_clr = 1'b0;
    chk(tmo_stat == 1'b1, "R7 set wins", tmo_stat, 1);
    chk(berr_drv == 1'b1, "R2 with clear", berr_drv, 1);
    release_all();
    repeat (SYNC + 2) @(negedge clk);
    clear_flag();

    // R9: back-to-back short cycles, then one long cycle
    for (int c = 0; c < 3; c++) begin
      @(negedge clk); as_n = 1'b0; ds_n = 2'b00;
      for (int k = 1; k <= LIMIT - 1; k++) begin
        @(negedge clk);
        chk(berr_drv == 1'b0, "R9 short", berr_drv, 0);
      end
      as_n = 1'b1; ds_n = 2'b11;
    end
    @(negedge clk); as_n = 1'b0; ds_n = 2'b00;
    for (int k = 1; k <= FIRE; k++) begin
      @(negedge clk);
      chk(berr_drv == (k >= FIRE), "R9 fresh timer", berr_drv, int'(k >= FIRE));
    end
    release_all();
    repeat (SYNC + 2) @(negedge clk);
    chk(tmo_stat == 1'b1, "R6 after long", tmo_stat, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule